// File: doc/BRIEF.md
# Configuration Status Register with Sticky Error Flags

This block is the 16-bit status word of a host bridge function's configuration header. It sits at byte offsets 6h and 7h. Five error flags live in the upper byte: a poisoned TLP was received, a system-error message was sent, an outgoing request got an Unsupported Request completion, an outgoing request got a Completer Abort completion, and a poisoned completion arrived. The link logic reports each of these as a one-cycle pulse on its own input. A flag stays set until software writes a 1 to its position.

The remaining bits are fixed constants. Bits 7 (fast back-to-back) and 4 (capability list present) read 1, and every other non-flag bit reads 0. Writes do not change any of them.

The poisoned-completion flag can only be set while the parity-error-enable input from the neighbouring command register is 1. Software uses a simple port to reach the register: a byte offset, a write strobe, a read strobe, two byte enables and 16-bit data. Read data comes from a register and appears one cycle after the read strobe.

Top module: `cfg_status_reg`

## Requirements
- R1: After a synchronous active-low reset, a read of the register returns 16'h0090.
- R2: A one-cycle pulse on the received-poisoned-TLP, system-error-sent, Unsupported-Request-completion or Completer-Abort-completion input sets bit 15, 14, 13 or 12 respectively. The bit stays 1 until it is cleared.
- R3: A pulse on the poisoned-completion input sets bit 8 only when parity-error-enable is 1 in that cycle. With the enable at 0, the bit stays unchanged.
- R4: A write that hits the register with byte enable 1 (upper byte) set clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R5: A write with byte enable 1 at 0 leaves bits 15..8 unchanged, whatever the write data.
- R6: If a flag's set event and a clearing write hit the same bit in the same cycle, the flag ends up set.
- R7: Bits 7 and 4 always read 1. Bits 11, 10, 9, 6, 5, 3, 2, 1 and 0 always read 0. Writes of any data to them have no effect.
- R8: A read strobe to offset 6h or 7h returns the register value on the read-data port one cycle later. In any cycle not preceded by such a read, read data is 0. Reading does not change any bit.
- R9: Offsets 6h and 7h both select the register. A write to any other offset changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | ADDR_W (12) | Configuration byte offset |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_be | input | 2 | Byte enables, bit 1 = bits 15..8 |
| cfg_wdata | input | 16 | Write data, 1 clears a flag |
| cfg_rdata | output | 16 | Registered read data |
| perr_enable | input | 1 | Parity-error enable from the command register |
| evt_poisoned_tlp | input | 1 | Poisoned TLP received (pulse) |
| evt_serr_sent | input | 1 | System-error message sent (pulse) |
| evt_ur_cpl | input | 1 | Unsupported Request completion received (pulse) |
| evt_ca_cpl | input | 1 | Completer Abort completion received (pulse) |
| evt_poisoned_cpl | input | 1 | Poisoned completion received (pulse) |

## Verification
The assertions assume that reset is applied synchronously and that every input is a known value at each rising edge. The byte-enable guard is checked only in cycles with no set events, because a set event that cycle may legally change a flag. The stimulus drives all inputs on falling edges and holds each event high for exactly one cycle. It then sweeps every combination of the five clear bits against all four byte-enable patterns, and it also writes 1s to the constant bits, so that the gating and the constant masks are exercised completely.

// File: rtl/cfg_status_pkg.sv
// Package: bit layout and fixed values of the configuration status word.
// Assumes a 16-bit register with five write-1-to-clear flags, all in the upper byte.
package cfg_status_pkg;

    localparam int STS_W     = 16;
    localparam int NUM_FLAGS = 5;
    localparam int NUM_BYTES = STS_W / 8;

    // Value of every hardwired bit; flag positions read 0 here.
    localparam logic [STS_W-1:0] CONST_VAL  = 16'h0090;
    // Bits that are hardwired (not flags).
    localparam logic [STS_W-1:0] CONST_MASK = 16'h0EFF;

    // Flag index to bit position: 0 poisoned cpl, 1 CA cpl, 2 UR cpl, 3 SERR sent, 4 poisoned TLP.
    function automatic int flag_pos(input int idx);
        case (idx)
            0:       return 8;
            1:       return 12;
            2:       return 13;
            3:       return 14;
            default: return 15;
        endcase
    endfunction

endpackage

// File: rtl/cfg_status_w1c_bit.sv
// Module: one sticky error flag.
// The flag is set by a pulse and cleared by a write-1 strobe; a set wins over a clear in the same cycle.
// Assumes the set and clear strobes are synchronous to clk.
module cfg_status_w1c_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // Flag register: reset to 0, set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o); // R6
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o); // R4
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(q_o)); // R2

endmodule

// File: rtl/cfg_status_event_map.sv
// Module: maps the link-logic event pulses onto the flag index order of the package.
// Gates the poisoned-completion event with the parity-error enable.
// Assumes the events are one-cycle pulses.
module cfg_status_event_map
    import cfg_status_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 perr_enable,
    input  logic                 evt_poisoned_tlp,
    input  logic                 evt_serr_sent,
    input  logic                 evt_ur_cpl,
    input  logic                 evt_ca_cpl,
    input  logic                 evt_poisoned_cpl,
    output logic [NUM_FLAGS-1:0] set_vec
);

    // Event routing in flag index order.
    always_comb begin
        set_vec[0] = evt_poisoned_cpl & perr_enable;
        set_vec[1] = evt_ca_cpl;
        set_vec[2] = evt_ur_cpl;
        set_vec[3] = evt_serr_sent;
        set_vec[4] = evt_poisoned_tlp;
    end

    AST_PERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_enable |-> !set_vec[0]); // R3

endmodule

// File: rtl/cfg_status_wr_decode.sv
// Module: turns a register write into per-flag clear strobes.
// A flag is cleared when the write hits, its byte is enabled and its data bit is 1.
// Assumes wr_hit already includes the address match.
module cfg_status_wr_decode
    import cfg_status_pkg::*;
(
    input  logic                 wr_hit,
    input  logic [NUM_BYTES-1:0] cfg_be,
    input  logic [STS_W-1:0]     cfg_wdata,
    output logic [NUM_FLAGS-1:0] clr_vec
);

    // Per-flag clear strobe from byte enable and data bit.
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_clr
        localparam int POS = flag_pos(g);
        assign clr_vec[g] = wr_hit & cfg_be[POS/8] & cfg_wdata[POS];
    end

    // Bits of the data and byte-enable buses that no flag uses.
    logic unused_wr_bits;
    assign unused_wr_bits = ^{cfg_wdata, cfg_be};

endmodule

// File: rtl/cfg_status_read_port.sv
// Module: registered read path of the configuration status word.
// Returns the word one cycle after a read hit and 0 otherwise.
// Assumes rd_hit already includes the address match.
module cfg_status_read_port
    import cfg_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_hit,
    input  logic [STS_W-1:0] status,
    output logic [STS_W-1:0] cfg_rdata
);

    // Capture the word on a read hit, drive zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rdata <= '0;
        end else if (rd_hit) begin
            cfg_rdata <= status;
        end else begin
            cfg_rdata <= '0;
        end
    end

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> (cfg_rdata == '0)); // R8

endmodule

// File: rtl/cfg_status_reg.sv
// Module: top of the configuration status register.
// Combines the sticky flags, the hardwired bits, address decode and the registered read port.
// Assumes a word-wide access port; the offsets STS_OFFSET and STS_OFFSET+1 both select the word.
module cfg_status_reg
    import cfg_status_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int STS_OFFSET = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [1:0]        cfg_be,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              perr_enable,
    input  logic              evt_poisoned_tlp,
    input  logic              evt_serr_sent,
    input  logic              evt_ur_cpl,
    input  logic              evt_ca_cpl,
    input  logic              evt_poisoned_cpl
);

    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(STS_OFFSET);

    logic                 addr_hit;
    logic                 wr_hit;
    logic                 rd_hit;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flags;
    logic [STS_W-1:0]     status;
    logic                 unused_addr_lsb;

    // Word address match; the byte-select bit is ignored.
    assign addr_hit = (cfg_addr[ADDR_W-1:1] == OFFS[ADDR_W-1:1]);
    assign wr_hit   = cfg_wr & addr_hit;
    assign rd_hit   = cfg_rd & addr_hit;
    assign unused_addr_lsb = cfg_addr[0];

    cfg_status_event_map u_event_map (
        .clk              (clk),
        .rst_n            (rst_n),
        .perr_enable      (perr_enable),
        .evt_poisoned_tlp (evt_poisoned_tlp),
        .evt_serr_sent    (evt_serr_sent),
        .evt_ur_cpl       (evt_ur_cpl),
        .evt_ca_cpl       (evt_ca_cpl),
        .evt_poisoned_cpl (evt_poisoned_cpl),
        .set_vec          (set_vec)
    );

    cfg_status_wr_decode u_wr_decode (
        .wr_hit    (wr_hit),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .clr_vec   (clr_vec)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        cfg_status_w1c_bit u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[g]),
            .clr_i (clr_vec[g]),
            .q_o   (flags[g])
        );
    end

    // Assemble the status word from constants and flags.
    always_comb begin
        status = CONST_VAL;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            status[flag_pos(i)] = flags[i];
        end
    end

    cfg_status_read_port u_read_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_hit    (rd_hit),
        .status    (status),
        .cfg_rdata (cfg_rdata)
    );

    AST_CONST_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> ((cfg_rdata & CONST_MASK) == CONST_VAL)); // R7
    AST_UPPER_BYTE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_be[1] && set_vec == '0) |=> $stable(flags)); // R5
    AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_hit && set_vec == '0) |=> $stable(flags)); // R9

endmodule

// File: tb/test_cfg_status_reg.sv
// Bench: self-checking sweeps of the configuration status register.
module test_cfg_status_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [1:0]  cfg_be = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        perr_enable = 1'b0;
    logic [4:0]  evt = '0; // order: 0 poisoned cpl, 1 CA, 2 UR, 3 SERR, 4 poisoned TLP

    int checks = 0;
    int errors = 0;
    logic [15:0] got;

    always #4 clk = ~clk; // 125 MHz

    cfg_status_reg i_cfg_status_reg (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_addr         (cfg_addr),
        .cfg_wr           (cfg_wr),
        .cfg_rd           (cfg_rd),
        .cfg_be           (cfg_be),
        .cfg_wdata        (cfg_wdata),
        .cfg_rdata        (cfg_rdata),
        .perr_enable      (perr_enable),
        .evt_poisoned_tlp (evt[4]),
        .evt_serr_sent    (evt[3]),
        .evt_ur_cpl       (evt[2]),
        .evt_ca_cpl       (evt[1]),
        .evt_poisoned_cpl (evt[0])
    );

    function automatic logic [15:0] spread(input logic [4:0] m);
        return 16'(((32'(m) & 1) << 8) | ((32'(m) >> 1) << 12));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [4:0] ev, input logic pen);
        @(negedge clk);
        evt = ev; perr_enable = pen;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] be, input logic [15:0] d, input logic [4:0] ev);
        @(negedge clk);
        cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1; evt = ev; perr_enable = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; evt = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_rd = 1'b1;
        @(negedge clk);
        cfg_rd = 1'b0;
        d = cfg_rdata;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %h expected %h", 16'h0, 16'h1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset value, R7 constants
        rd(12'h006, got);
        chk(got == 16'h0090, "R1 reset", got, 16'h0090);
        chk((got & 16'h0EFF) == 16'h0090, "R7 const", got, 16'h0090);
        // R8 no read strobe gives zero
        @(negedge clk);
        chk(cfg_rdata == 16'h0, "R8 idle", cfg_rdata, 16'h0);

        // R2 each event sets its bit; R4 write-1 clears it
        for (int i = 1; i < 5; i++) begin
            pulse(5'(1 << i), 1'b0);
            rd(12'h006, got);
            chk(got == (16'h0090 | spread(5'(1 << i))), "R2 set", got, 16'h0090 | spread(5'(1 << i)));
            rd(12'h006, got);
            chk(got == (16'h0090 | spread(5'(1 << i))), "R8 no side effect", got, 16'h0090 | spread(5'(1 << i)));
            wr(12'h006, 2'b11, spread(5'(1 << i)), 5'b0);
            rd(12'h006, got);
            chk(got == 16'h0090, "R4 clear", got, 16'h0090);
        end

        // R3 parity-enable gating
        pulse(5'b00001, 1'b0);
        rd(12'h006, got);
        chk(got == 16'h0090, "R3 gated off", got, 16'h0090);
        pulse(5'b00001, 1'b1);
        rd(12'h006, got);
        chk(got == 16'h0190, "R3 enabled", got, 16'h0190);
        wr(12'h006, 2'b10, 16'h0100, 5'b0);

        // R4 writing 0 keeps flags
        pulse(5'b11111, 1'b1);
        wr(12'h006, 2'b11, 16'h0000, 5'b0);
        rd(12'h006, got);
        chk(got == 16'hF190, "R4 write zero", got, 16'hF190);

        // R9 other offsets ignored, offset 7 selects
        wr(12'h004, 2'b11, 16'hFFFF, 5'b0);
        wr(12'h008, 2'b11, 16'hFFFF, 5'b0);
        rd(12'h006, got);
        chk(got == 16'hF190, "R9 miss write", got, 16'hF190);
        rd(12'h004, got);
        chk(got == 16'h0000, "R8 miss read", got, 16'h0000);
        rd(12'h007, got);
        chk(got == 16'hF190, "R9 odd read", got, 16'hF190);
        wr(12'h007, 2'b10, 16'h8000, 5'b0);
        rd(12'h006, got);
        chk(got == 16'h7190, "R9 odd write", got, 16'h7190);

        // R6 set wins over a simultaneous clear
        wr(12'h006, 2'b11, 16'hF100, 5'b01000);
        rd(12'h006, got);
        chk(got == 16'h4090, "R6 set wins", got, 16'h4090);

        // R4 R5 R7 sweep of clear masks and byte enables
        for (int m = 0; m < 32; m++) begin
            for (int b = 0; b < 4; b++) begin
                logic [15:0] expv;
                pulse(5'b11111, 1'b1);
                wr(12'h006, 2'(b), spread(5'(m)) | 16'h0EFF, 5'b0);
                expv = 16'h0090 | (((b & 2) != 0) ? (16'hF100 & ~spread(5'(m))) : 16'hF100);
                rd(12'h006, got);
                chk(got == expv, "R5 sweep", got, expv);
            end
        end

        // R1 reset again clears flags
        pulse(5'b11111, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(12'h006, got);
        chk(got == 16'h0090, "R1 re-reset", got, 16'h0090);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule